// File: doc/BRIEF.md
# DMA Bus Access Filter

This block sits between a DMA sequencer and a system bus that has two address regions. One is a 24-bit "A" space. The other is an 8-bit "B" register page, whose 16-bit address is always 0x2100 OR'd with an 8-bit offset. Each request moves a single byte. A request is one of three kinds:

- a read, issued on a chosen bus;
- a write, issued on a chosen bus;
- a copy, which reads on one bus and then writes on the other.

For every access the block decides one of three outcomes:

- it reaches the target through a response port;
- it is answered with the open-bus latch;
- it is dropped.

Accesses issued on the A bus never reach the B-register page. DMA never reaches its own control registers.

Every access occupies a fixed window of master-clock cycles. A copy between work RAM and the B-page work-RAM data port (offset 0x80) is degraded: from B to A it writes a garbage byte, and from A to B it writes nothing. The full timing is still spent in both cases. At the end of each request the block raises a one-cycle done pulse. The pulse carries the byte the request moved and the number of cycles it consumed.

Top module: `dma_bus_filter`

## Requirements
- R1: An access issued on the A bus whose page (bits [23:12]) decodes as B-register page creates no strobe. A read of this kind returns the open-bus latch. This includes the read half of a copy.
- R2: A write issued on the A bus to the B-register page is discarded. No A or B write strobe occurs, and rdata_o reports the byte that was offered.
- R3: On an A-register page, the offsets 0x420B, 0x420C and 0x4300 to 0x437F are blocked. Reads return open bus, writes are discarded, and neither creates a strobe. Offsets 0x420A and 0x4380 pass through.
- R4: Each access window is 4 clock cycles, and each window has exactly one strobe at most. A read or a write reports cycles_o = 4. A copy reports 8. done_o is high for one cycle, 4N+1 falling edges after the accepting edge, where N is the number of windows.
- R5: A copy from B to A (b_to_a_i=1) at B offset 0x80 whose A address is work RAM makes no B read. Its second window writes 0xFF to the A address, and it reports 8 cycles.
- R6: A copy from A to B from work RAM to B offset 0x80 makes no strobe at all and still reports 8 cycles.
- R7: A read that reaches a response port loads the open-bus latch with the returned byte. Reads answered from the latch, all writes, and the degraded copies leave the latch unchanged. A read on an unmapped page returns the latch.
- R8: Every B strobe carries b_addr_o = 0x2100 | b_off_i.
- R9: Page decode works as follows:
  - banks 0x7E and 0x7F are work RAM;
  - in banks with bit 6 clear, pages 0 and 1 are work RAM, page 2 is the B-register page and page 4 is the A-register page;
  - in those same banks, pages 8 to F are other memory and all other pages are unmapped;
  - every other bank is other memory.
- R10: After reset, busy_o, done_o, rdata_o and cycles_o are 0, no strobe is active, and the open-bus latch holds 0x00.
- R11: Requests are accepted only while busy_o is low. Inputs that change during a request have no effect on it. A request held high in the done cycle is accepted on the next edge.
- R12: The op_i encoding is 0 for read, 1 for write and 2 for copy; 3 acts as read. bus_b_i=1 selects the B bus. rdata_o reports the byte the request moved: the byte read, the byte offered for a write, or the byte written by a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, sampled while idle |
| op_i | input | 2 | 0 read, 1 write, 2 copy |
| bus_b_i | input | 1 | Read/write issued on the B bus |
| b_to_a_i | input | 1 | Copy direction, B source to A destination |
| a_addr_i | input | 24 | A-bus address |
| b_off_i | input | 8 | B-page register offset |
| wdata_i | input | 8 | Write byte for write requests |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte moved by the finished request |
| cycles_o | output | 8 | Master cycles consumed by the finished request |
| a_rd_o | output | 1 | A-port read strobe |
| a_wr_o | output | 1 | A-port write strobe |
| a_addr_o | output | 24 | A-port address |
| a_wdata_o | output | 8 | A-port write byte |
| a_rdata_i | input | 8 | A-port read byte, same cycle as strobe |
| b_rd_o | output | 1 | B-port read strobe |
| b_wr_o | output | 1 | B-port write strobe |
| b_addr_o | output | 16 | B-port address |
| b_wdata_o | output | 8 | B-port write byte |
| b_rdata_i | input | 8 | B-port read byte, same cycle as strobe |

## Verification
Two events can fall on the same edge: the completion of one request, which loads the open-bus latch and pulses done, and the acceptance of the next request. To provoke this, a B read is issued and req_i is kept high into its done cycle, with the next request's fields already pointing at an unmapped A page. The bench judges the pair in two steps. It checks that busy_o rises on the edge right after done. It then checks that the second request returns the byte the first request just latched, after exactly one access window.

// File: rtl/dma_filt_pkg.sv
package dma_filt_pkg;

  typedef enum logic [2:0] {
    PG_UNMAPPED,
    PG_AREG,
    PG_BREG,
    PG_WRAM,
    PG_MEM
  } page_kind_e;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_PORT_A,
    ACT_PORT_B,
    ACT_OPEN,
    ACT_DROP
  } act_e;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_COPY  = 2'd2;

  // DMA controller's own register offsets inside the A-register page
  function automatic logic is_dma_reg(input logic [15:0] off);
    return (off == 16'h420B) || (off == 16'h420C) || (off[15:7] == 9'h086);
  endfunction

endpackage

// File: rtl/dma_page_decode.sv
module dma_page_decode
  import dma_filt_pkg::*;
#(
  parameter logic [7:0] WRAM_BANK_A     = 8'h7E,
  parameter logic [7:0] WRAM_BANK_B     = 8'h7F,
  parameter bit         MIRROR_LOW_WRAM = 1'b1
) (
  input  logic [23:0] addr_i,
  output page_kind_e  kind_o,
  output logic        dma_reg_o
);
  logic [7:0] bank;
  logic [3:0] page;
  page_kind_e low_kind;

  assign bank = addr_i[23:16];
  assign page = addr_i[15:12];

  generate
    if (MIRROR_LOW_WRAM) begin : g_mirror
      assign low_kind = PG_WRAM;
    end else begin : g_no_mirror
      assign low_kind = PG_UNMAPPED;
    end
  endgenerate

  always_comb begin
    if (bank == WRAM_BANK_A || bank == WRAM_BANK_B) begin
      kind_o = PG_WRAM;
    end else if (!bank[6]) begin
      unique case (page)
        4'h0, 4'h1: kind_o = low_kind;
        4'h2:       kind_o = PG_BREG;
        4'h4:       kind_o = PG_AREG;
        4'h8, 4'h9, 4'hA, 4'hB,
        4'hC, 4'hD, 4'hE, 4'hF: kind_o = PG_MEM;
        default:    kind_o = PG_UNMAPPED;
      endcase
    end else begin
      kind_o = PG_MEM;
    end
  end

  assign dma_reg_o = (kind_o == PG_AREG) && is_dma_reg(addr_i[15:0]);

endmodule

// File: rtl/dma_access_gate.sv
module dma_access_gate
  import dma_filt_pkg::*;
(
  input  logic       bus_b_i,
  input  logic       wr_i,
  input  page_kind_e kind_i,
  input  logic       dma_reg_i,
  output act_e       act_o
);
  always_comb begin
    if (bus_b_i) begin
      act_o = ACT_PORT_B;
    end else if (kind_i == PG_BREG || kind_i == PG_UNMAPPED || dma_reg_i) begin
      act_o = wr_i ? ACT_DROP : ACT_OPEN;
    end else begin
      act_o = ACT_PORT_A;
    end
  end
endmodule

// File: rtl/dma_bus_filter.sv
module dma_bus_filter
  import dma_filt_pkg::*;
#(
  parameter int         CLK_PER_ACC     = 4,
  parameter int         CNT_W           = 8,
  parameter logic [7:0] WRAM_BANK_A     = 8'h7E,
  parameter logic [7:0] WRAM_BANK_B     = 8'h7F,
  parameter bit         MIRROR_LOW_WRAM = 1'b1,
  parameter logic [7:0] WRAM_PORT_OFF   = 8'h80,
  parameter logic [7:0] GARBAGE_BYTE    = 8'hFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [1:0]  op_i,
  input  logic        bus_b_i,
  input  logic        b_to_a_i,
  input  logic [23:0] a_addr_i,
  input  logic [7:0]  b_off_i,
  input  logic [7:0]  wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  rdata_o,
  output logic [7:0]  cycles_o,
  output logic        a_rd_o,
  output logic        a_wr_o,
  output logic [23:0] a_addr_o,
  output logic [7:0]  a_wdata_o,
  input  logic [7:0]  a_rdata_i,
  output logic        b_rd_o,
  output logic        b_wr_o,
  output logic [15:0] b_addr_o,
  output logic [7:0]  b_wdata_o,
  input  logic [7:0]  b_rdata_i
);
  localparam int         ACC_W   = (CLK_PER_ACC > 1) ? $clog2(CLK_PER_ACC) : 1;
  localparam logic [7:0] B_PAGE  = 8'h21;
  localparam logic [ACC_W-1:0] ACC_LAST = ACC_W'(CLK_PER_ACC - 1);

  logic             busy_q, done_q, ph_q, bus_q, b2a_q;
  logic [1:0]       op_q;
  logic [ACC_W-1:0] cnt_q;
  logic [CNT_W-1:0] tot_q, cyc_q;
  logic [23:0]      addr_q;
  logic [7:0]       off_q, wdata_q, xfer_q, open_q, rdata_q;

  page_kind_e a_kind;
  logic       a_dma_reg;
  act_e       act, act_eff;

  logic       is_copy, wram_port, ph_bus_b, ph_wr, ph_skip, last_ph, acc_end;
  logic [7:0] ph_data, rd_val;

  dma_page_decode #(
    .WRAM_BANK_A    (WRAM_BANK_A),
    .WRAM_BANK_B    (WRAM_BANK_B),
    .MIRROR_LOW_WRAM(MIRROR_LOW_WRAM)
  ) u_decode (
    .addr_i   (addr_q),
    .kind_o   (a_kind),
    .dma_reg_o(a_dma_reg)
  );

  // current window: which bus, which direction, skipped or not
  always_comb begin
    is_copy   = (op_q == OP_COPY);
    wram_port = is_copy && (off_q == WRAM_PORT_OFF) && (a_kind == PG_WRAM);
    ph_bus_b  = is_copy ? (ph_q ? !b2a_q : b2a_q) : bus_q;
    ph_wr     = is_copy ? ph_q : (op_q == OP_WRITE);
    ph_skip   = wram_port && (!ph_q || !b2a_q);
    ph_data   = is_copy ? (wram_port ? GARBAGE_BYTE : xfer_q) : wdata_q;
    last_ph   = !is_copy || ph_q;
    acc_end   = busy_q && (cnt_q == ACC_LAST);
  end

  dma_access_gate u_gate (
    .bus_b_i  (ph_bus_b),
    .wr_i     (ph_wr),
    .kind_i   (a_kind),
    .dma_reg_i(a_dma_reg),
    .act_o    (act)
  );

  assign act_eff = ph_skip ? ACT_IDLE : act;

  always_comb begin
    unique case (act_eff)
      ACT_PORT_A: rd_val = a_rdata_i;
      ACT_PORT_B: rd_val = b_rdata_i;
      ACT_IDLE:   rd_val = GARBAGE_BYTE;
      default:    rd_val = open_q;
    endcase
  end

  assign a_rd_o    = acc_end && (act_eff == ACT_PORT_A) && !ph_wr;
  assign a_wr_o    = acc_end && (act_eff == ACT_PORT_A) &&  ph_wr;
  assign b_rd_o    = acc_end && (act_eff == ACT_PORT_B) && !ph_wr;
  assign b_wr_o    = acc_end && (act_eff == ACT_PORT_B) &&  ph_wr;
  assign a_addr_o  = addr_q;
  assign b_addr_o  = {B_PAGE, off_q};
  assign a_wdata_o = ph_data;
  assign b_wdata_o = ph_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ph_q    <= 1'b0;
      bus_q   <= 1'b0;
      b2a_q   <= 1'b0;
      op_q    <= OP_READ;
      cnt_q   <= '0;
      tot_q   <= '0;
      cyc_q   <= '0;
      addr_q  <= '0;
      off_q   <= '0;
      wdata_q <= '0;
      xfer_q  <= '0;
      open_q  <= '0;
      rdata_q <= '0;
    end else if (!busy_q) begin
      done_q <= 1'b0;
      if (req_i) begin
        busy_q  <= 1'b1;
        ph_q    <= 1'b0;
        cnt_q   <= '0;
        tot_q   <= '0;
        op_q    <= op_i;
        bus_q   <= bus_b_i;
        b2a_q   <= b_to_a_i;
        addr_q  <= a_addr_i;
        off_q   <= b_off_i;
        wdata_q <= wdata_i;
      end
    end else begin
      tot_q <= tot_q + 1'b1;
      if (acc_end) begin
        cnt_q <= '0;
        if (!ph_wr) begin
          xfer_q <= rd_val;
          if (act_eff == ACT_PORT_A || act_eff == ACT_PORT_B) open_q <= rd_val;
        end
        if (last_ph) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          cyc_q   <= tot_q + 1'b1;
          rdata_q <= ph_wr ? ph_data : rd_val;
        end else begin
          ph_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;
  assign cycles_o = 8'(cyc_q);

endmodule

// File: rtl/dma_bus_filter_chk.sv
module dma_bus_filter_chk
  import dma_filt_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic [7:0]  cycles_o,
  input logic        a_rd_o,
  input logic        a_wr_o,
  input logic [23:0] a_addr_o,
  input logic        b_rd_o,
  input logic        b_wr_o,
  input logic [15:0] b_addr_o
);
  p_single_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({a_rd_o, a_wr_o, b_rd_o, b_wr_o}));

  p_a_skips_b_page_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_rd_o || a_wr_o) |-> ((a_addr_o & 24'h40F000) != 24'h002000));

  p_a_skips_dma_regs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_rd_o || a_wr_o) && ((a_addr_o & 24'h40F000) == 24'h004000)
      |-> !is_dma_reg(a_addr_o[15:0]));

  p_b_page_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_rd_o || b_wr_o) |-> (b_addr_o[15:8] == 8'h21));

  p_cycle_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cycles_o == 8'd4 || cycles_o == 8'd8));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o));

  p_strobe_in_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_rd_o || a_wr_o || b_rd_o || b_wr_o) |-> busy_o);
endmodule

bind dma_bus_filter dma_bus_filter_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cycles_o(cycles_o),
  .a_rd_o  (a_rd_o),
  .a_wr_o  (a_wr_o),
  .a_addr_o(a_addr_o),
  .b_rd_o  (b_rd_o),
  .b_wr_o  (b_wr_o),
  .b_addr_o(b_addr_o)
);

// File: tb/dma_bus_filter_bench.sv
`timescale 1ns/1ps
module dma_bus_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        bus_b = 1'b0, b2a = 1'b0;
  logic [23:0] a_addr = '0;
  logic [7:0]  b_off = '0, wdata = '0;
  logic        busy, done;
  logic [7:0]  rdata, cycles;
  logic        a_rd, a_wr, b_rd, b_wr;
  logic [23:0] a_addr_o;
  logic [7:0]  a_wdata, a_rdata, b_wdata, b_rdata;
  logic [15:0] b_addr_o;

  always #4 clk = ~clk;

  // response models: computed contents
  assign a_rdata = a_addr_o[7:0] ^ 8'h5A;
  assign b_rdata = b_addr_o[7:0] ^ 8'hC3;

  dma_bus_filter u_dma_bus_filter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .bus_b_i(bus_b),
    .b_to_a_i(b2a), .a_addr_i(a_addr), .b_off_i(b_off), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .cycles_o(cycles),
    .a_rd_o(a_rd), .a_wr_o(a_wr), .a_addr_o(a_addr_o), .a_wdata_o(a_wdata),
    .a_rdata_i(a_rdata), .b_rd_o(b_rd), .b_wr_o(b_wr), .b_addr_o(b_addr_o),
    .b_wdata_o(b_wdata), .b_rdata_i(b_rdata)
  );

  int n_ard = 0, n_awr = 0, n_brd = 0, n_bwr = 0;
  logic [23:0] last_a_addr = '0;
  logic [15:0] last_b_addr = '0;
  logic [7:0]  last_a_wd = '0, last_b_wd = '0;

  always @(posedge clk) begin
    if (a_rd) n_ard++;
    if (a_wr) begin n_awr++; last_a_wd = a_wdata; end
    if (a_rd || a_wr) last_a_addr = a_addr_o;
    if (b_rd) n_brd++;
    if (b_wr) begin n_bwr++; last_b_wd = b_wdata; end
    if (b_rd || b_wr) last_b_addr = b_addr_o;
  end

  int errors = 0, checks = 0;
  int d_ard, d_awr, d_brd, d_bwr, lat;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic wait_done();
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_req(input logic [1:0] o, input logic bb, input logic ba,
                         input logic [23:0] a, input logic [7:0] off, input logic [7:0] wd);
    int s_ard, s_awr, s_brd, s_bwr;
    @(negedge clk);
    s_ard = n_ard; s_awr = n_awr; s_brd = n_brd; s_bwr = n_bwr;
    op = o; bus_b = bb; b2a = ba; a_addr = a; b_off = off; wdata = wd; req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    wait_done();
    d_ard = n_ard - s_ard; d_awr = n_awr - s_awr;
    d_brd = n_brd - s_brd; d_bwr = n_bwr - s_bwr;
  endtask

  task automatic chk_none(input string rq);
    chk(rq, "strobes", d_ard + d_awr + d_brd + d_bwr, 0);
  endtask

  task automatic t_reset();
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);
    chk("R10", "rdata", rdata, 0);
    chk("R10", "cycles", cycles, 0);
    chk("R10", "strobes", {a_rd, a_wr, b_rd, b_wr}, 0);
    run_req(2'd0, 1'b0, 1'b0, 24'h035000, 8'h00, 8'h00);
    chk("R10", "open bus after reset", rdata, 8'h00);
    chk_none("R10");
  endtask

  task automatic t_b_read();
    run_req(2'd0, 1'b1, 1'b0, 24'h0, 8'h18, 8'h00);
    chk("R8", "b read data", rdata, 8'hDB);
    chk("R8", "b addr", last_b_addr, 16'h2118);
    chk("R4", "b read strobes", d_brd, 1);
    chk("R4", "read cycles", cycles, 4);
    chk("R4", "read latency", lat, 5);
  endtask

  task automatic t_a_open_bus();
    run_req(2'd0, 1'b0, 1'b0, 24'h035000, 8'h00, 8'h00);
    chk("R7", "unmapped read", rdata, 8'hDB);
    chk_none("R7");
    run_req(2'd0, 1'b0, 1'b0, 24'h012118, 8'h00, 8'h00);
    chk("R1", "A read of B page", rdata, 8'hDB);
    chk_none("R1");
    run_req(2'd0, 1'b0, 1'b0, 24'h7E1234, 8'h00, 8'h00);
    chk("R9", "wram read", rdata, 8'h6E);
    chk("R9", "wram strobe", d_ard, 1);
    chk("R9", "wram addr", last_a_addr, 24'h7E1234);
    run_req(2'd3, 1'b0, 1'b0, 24'h405000, 8'h00, 8'h00);
    chk("R12", "op3 read other mem", rdata, 8'h5A);
    chk("R9", "other mem strobe", d_ard, 1);
  endtask

  task automatic t_dma_regs();
    run_req(2'd0, 1'b0, 1'b0, 24'h00420A, 8'h00, 8'h00);
    chk("R3", "420A passes", rdata, 8'h50);
    chk("R3", "420A strobe", d_ard, 1);
    run_req(2'd0, 1'b0, 1'b0, 24'h00420B, 8'h00, 8'h00);
    chk("R3", "420B open", rdata, 8'h50);
    chk_none("R3");
    run_req(2'd0, 1'b0, 1'b0, 24'h80420C, 8'h00, 8'h00);
    chk("R3", "420C open", rdata, 8'h50);
    chk_none("R3");
    run_req(2'd0, 1'b0, 1'b0, 24'h004300, 8'h00, 8'h00);
    chk("R3", "4300 open", rdata, 8'h50);
    chk_none("R3");
    run_req(2'd0, 1'b0, 1'b0, 24'h00437F, 8'h00, 8'h00);
    chk("R3", "437F open", rdata, 8'h50);
    chk_none("R3");
    run_req(2'd0, 1'b0, 1'b0, 24'h004380, 8'h00, 8'h00);
    chk("R3", "4380 passes", rdata, 8'hDA);
    chk("R3", "4380 strobe", d_ard, 1);
    run_req(2'd1, 1'b0, 1'b0, 24'h004310, 8'h00, 8'h11);
    chk_none("R3");
    run_req(2'd1, 1'b0, 1'b0, 24'h00420B, 8'h00, 8'h12);
    chk_none("R3");
  endtask

  task automatic t_a_writes();
    run_req(2'd1, 1'b0, 1'b0, 24'h002118, 8'h00, 8'h22);
    chk_none("R2");
    chk("R2", "dropped write rdata", rdata, 8'h22);
    chk("R4", "write cycles", cycles, 4);
    run_req(2'd1, 1'b0, 1'b0, 24'h7E0010, 8'h00, 8'h99);
    chk("R12", "a write strobe", d_awr, 1);
    chk("R12", "a write addr", last_a_addr, 24'h7E0010);
    chk("R12", "a write data", last_a_wd, 8'h99);
    run_req(2'd1, 1'b1, 1'b0, 24'h0, 8'h34, 8'h77);
    chk("R8", "b write strobe", d_bwr, 1);
    chk("R8", "b write addr", last_b_addr, 16'h2134);
    chk("R8", "b write data", last_b_wd, 8'h77);
    run_req(2'd0, 1'b0, 1'b0, 24'h005000, 8'h00, 8'h00);
    chk("R7", "latch after writes", rdata, 8'hDA);
  endtask

  task automatic t_copies();
    run_req(2'd2, 1'b0, 1'b0, 24'h7E0020, 8'h18, 8'h00);
    chk("R4", "copy a2b cycles", cycles, 8);
    chk("R4", "copy latency", lat, 9);
    chk("R12", "a2b strobes", {d_ard[3:0], d_bwr[3:0]}, 8'h11);
    chk("R8", "a2b dest", last_b_addr, 16'h2118);
    chk("R12", "a2b data", last_b_wd, 8'h7A);
    chk("R12", "a2b rdata", rdata, 8'h7A);
    run_req(2'd2, 1'b0, 1'b1, 24'h7E0030, 8'h22, 8'h00);
    chk("R12", "b2a strobes", {d_brd[3:0], d_awr[3:0]}, 8'h11);
    chk("R12", "b2a dest", last_a_addr, 24'h7E0030);
    chk("R12", "b2a data", last_a_wd, 8'hE1);
    run_req(2'd2, 1'b0, 1'b0, 24'h002100, 8'h10, 8'h00);
    chk("R1", "copy src B page no a_rd", d_ard, 0);
    chk("R1", "copy src open-bus data", last_b_wd, 8'hE1);
    chk("R1", "copy dest strobe", d_bwr, 1);
  endtask

  task automatic t_wram_port();
    run_req(2'd2, 1'b0, 1'b1, 24'h7E0040, 8'h80, 8'h00);
    chk("R5", "no b read", d_brd, 0);
    chk("R5", "garbage write strobe", d_awr, 1);
    chk("R5", "garbage addr", last_a_addr, 24'h7E0040);
    chk("R5", "garbage data", last_a_wd, 8'hFF);
    chk("R5", "cycles", cycles, 8);
    run_req(2'd2, 1'b0, 1'b1, 24'h000100, 8'h80, 8'h00);
    chk("R5", "mirror garbage", {d_brd[3:0], d_awr[3:0]}, 8'h01);
    chk("R5", "mirror data", last_a_wd, 8'hFF);
    run_req(2'd2, 1'b0, 1'b0, 24'h7E0050, 8'h80, 8'h00);
    chk_none("R6");
    chk("R6", "cycles", cycles, 8);
    chk("R6", "latency", lat, 9);
    run_req(2'd0, 1'b0, 1'b0, 24'h005000, 8'h00, 8'h00);
    chk("R7", "latch after special copies", rdata, 8'hE1);
    run_req(2'd2, 1'b0, 1'b1, 24'h808000, 8'h80, 8'h00);
    chk("R5", "non-wram dest is normal", {d_brd[3:0], d_awr[3:0]}, 8'h11);
    chk("R5", "non-wram data", last_a_wd, 8'h43);
  endtask

  task automatic t_back_to_back();
    int s_ard, s_brd;
    @(negedge clk);
    s_ard = n_ard; s_brd = n_brd;
    op = 2'd0; bus_b = 1'b1; b_off = 8'h05; req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_b = 1'b0; a_addr = 24'h005000; b_off = 8'h99;
    wait_done();
    chk("R11", "first result unaffected", rdata, 8'hC6);
    chk("R11", "first strobes", {4'(n_brd - s_brd), 4'(n_ard - s_ard)}, 8'h10);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk("R11", "accepted in done cycle", busy, 1);
    wait_done();
    chk("R11", "second latency", lat, 5);
    chk("R7", "second sees fresh latch", rdata, 8'hC6);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_b_read();
    t_a_open_bus();
    t_dma_regs();
    t_a_writes();
    t_copies();
    t_wram_port();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule